// File: doc/BRIEF.md
# ADC Scan Sequencer with Sample FIFO

This block drives a multiplexed analog-to-digital acquisition front end. Software programs a contiguous group of input channels and a trigger source. Each trigger pulse then starts one scan. The sequencer sets the multiplexer to each channel of the group in turn and runs one conversion per channel through a start/done handshake with the converter. When the last channel is done, it returns the multiplexer to the group's first channel.

Each 16-bit result goes one of two ways. It is appended to a first-word-fall-through sample FIFO, and an interrupt is raised once the fill count reaches a programmed level. Or it is latched into a holding register, and an interrupt is raised for every sample. Software can also bypass the scan and start one conversion on a channel it picks. A trigger that arrives during a scan and a sample that arrives at a full FIFO each set a sticky flag, and software clears each flag by writing a one to it.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, `irq`, `adc_start`, `overrun_flag` and `overflow_flag` are 0, `fifo_empty` is 1, `fifo_count` is 0 and `mux_ch` is 0.
- R2: The control register (address 0) holds the scan enable in bit 3 and the trigger select in bit 2. With select 0 only `timer_tick` starts a scan, and with select 1 only `ext_trig` does. The other input has no effect, and no scan starts while bit 3 is 0.
- R3: `adc_start` is a one-cycle pulse, issued once per conversion. The result is taken on the cycle `adc_done` is high, and the next channel's start follows.
- R4: The group register (address 1) holds the first channel in bits [3:0] and the channel count minus one in bits [11:8]. A scan converts first, first+1, and so on, wrapping modulo 16 in single-ended mode. In differential mode (control bit 0) it wraps modulo 8, uses only the first channel's low three bits, and converts at most 8 channels.
- R5: While no conversion is running, `mux_ch` equals the group's first channel, including right after a scan or a single conversion ends.
- R6: A scan trigger that arrives while a conversion is in progress starts nothing and sets `overrun_flag`. Writing 1 to bit 0 of address 4 clears the flag.
- R7: With the FIFO enabled (control bit 1), every result is stored in order. `fifo_rdata` shows the oldest entry, `fifo_rd` removes it, and a read of an empty FIFO is ignored.
- R8: In FIFO mode, `irq` is high while `fifo_count` is at least the threshold register (address 2) and the threshold is nonzero.
- R9: A result that arrives while the FIFO is full is dropped and sets `overflow_flag`. The count and the contents are unchanged. Writing 1 to bit 1 of address 4 clears the flag.
- R10: With the FIFO disabled, each result is loaded into `hold_data` and sets a pending interrupt shown on `irq`. A `hold_ack` pulse clears the pending interrupt.
- R11: A write to address 3 starts one conversion on channel wdata[3:0] (low three bits in differential mode) when the sequencer is idle. The write is ignored while a conversion is running.
- R12: A FIFO write and a FIFO read in the same cycle leave `fifo_count` unchanged and keep the data in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| timer_tick | input | 1 | Timer trigger pulse |
| ext_trig | input | 1 | External trigger pulse |
| adc_start | output | 1 | Start-of-conversion pulse to the converter |
| adc_done | input | 1 | Conversion finished, data valid |
| adc_data | input | 16 | Conversion result |
| mux_ch | output | 4 | Multiplexer channel select |
| fifo_rd | input | 1 | FIFO read strobe |
| fifo_rdata | output | 16 | Oldest FIFO entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_count | output | FIFO_AW+1 | FIFO fill count |
| hold_data | output | 16 | Last result in non-FIFO mode |
| hold_ack | input | 1 | Clears the per-sample interrupt |
| irq | output | 1 | Interrupt request |
| overrun_flag | output | 1 | Sticky trigger-overrun flag |
| overflow_flag | output | 1 | Sticky FIFO-overflow flag |

## Verification
The two functions that can land on the same clock edge are a FIFO append from a finished conversion and a FIFO removal by the reader. To provoke this, the converter model raises `fifo_rd` on the exact cycle it presents `adc_done`, whenever the FIFO is not empty. After a four-channel scan run this way, the fill count must sit at one. Every word popped along the way must match, in order, the channels predicted from the group setting.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  // Control register layout, most significant field first
  typedef struct packed {
    logic scan_en;
    logic trig_ext;
    logic fifo_en;
    logic diff;
  } seq_ctrl_t;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_GROUP = 3'd1;
  localparam logic [2:0] ADDR_THR   = 3'd2;
  localparam logic [2:0] ADDR_SOFT  = 3'd3;
  localparam logic [2:0] ADDR_CLR   = 3'd4;

endpackage

// File: rtl/adc_seq_fifo.sv
`timescale 1ns/1ps
module adc_seq_fifo #(
  parameter int DATA_W = 16,
  parameter int AW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full,
  output logic [AW:0]       count
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == DEPTH_C);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr_q];
  assign count   = cnt_q;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = wptr_q + 1'b1;
    if (pop_ok)  rptr_d = rptr_q + 1'b1;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + 1'b1;
    else if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  // R9: a write into a full FIFO without a read leaves the count alone
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (count == $past(count)));

  // R12: simultaneous write and read keep the count
  a_r12_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !full) |=> (count == $past(count)));

  // R7: a read of an empty FIFO changes nothing
  a_r7_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              diff,
  input  logic              trig,
  input  logic [NCH_W-1:0]  first_ch,
  input  logic [NCH_W-1:0]  len_m1,
  input  logic              soft_go,
  input  logic [NCH_W-1:0]  soft_ch,
  input  logic              adc_done,
  input  logic [DATA_W-1:0] adc_data,
  output logic              adc_start,
  output logic [NCH_W-1:0]  mux_ch,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              overrun_set
);
  localparam int HALF = 1 << (NCH_W-1);
  localparam logic [NCH_W-1:0] HALF_MASK = NCH_W'(HALF-1);
  localparam logic [NCH_W-1:0] FULL_MASK = {NCH_W{1'b1}};

  seq_state_t       state_q, state_d;
  logic [NCH_W-1:0] idx_q, idx_d, ch_q, ch_d;
  logic             single_q, single_d;
  logic [NCH_W-1:0] ch_mask, first_m, len_eff;

  assign ch_mask = diff ? HALF_MASK : FULL_MASK;
  assign first_m = first_ch & ch_mask;
  assign len_eff = (diff && (len_m1 > HALF_MASK)) ? HALF_MASK : len_m1;

  always_comb begin
    state_d     = state_q;
    idx_d       = idx_q;
    ch_d        = ch_q;
    single_d    = single_q;
    smp_valid   = 1'b0;
    overrun_set = 1'b0;
    case (state_q)
      ST_IDLE: begin
        ch_d     = first_m;
        idx_d    = '0;
        single_d = 1'b0;
        if (trig) begin
          state_d = ST_START;
        end else if (soft_go) begin
          state_d  = ST_START;
          ch_d     = soft_ch & ch_mask;
          single_d = 1'b1;
        end
      end
      ST_START: state_d = ST_WAIT;
      ST_WAIT: begin
        if (adc_done) begin
          smp_valid = 1'b1;
          if (single_q || (idx_q == len_eff)) begin
            state_d = ST_IDLE;
            ch_d    = first_m;
            idx_d   = '0;
          end else begin
            state_d = ST_START;
            idx_d   = idx_q + 1'b1;
            ch_d    = (ch_q + 1'b1) & ch_mask;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (trig && (state_q != ST_IDLE)) overrun_set = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      ch_q     <= '0;
      single_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      idx_q    <= idx_d;
      ch_q     <= ch_d;
      single_q <= single_d;
    end
  end

  assign adc_start = (state_q == ST_START);
  assign mux_ch    = ch_q;
  assign smp_data  = adc_data;

  // R3: the start strobe never lasts two cycles
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R3: no new start while a conversion is still outstanding
  a_r3_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !adc_done) |=> !adc_start);

  // R11: a single conversion ends after exactly one result
  a_r11_single_end: assert property (@(posedge clk) disable iff (!rst_n)
    (single_q && smp_valid) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/adc_scan_seq.sv
`timescale 1ns/1ps
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH_W   = 4,
  parameter int DATA_W  = 16,
  parameter int FIFO_AW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [15:0]        cfg_wdata,
  input  logic               timer_tick,
  input  logic               ext_trig,
  output logic               adc_start,
  input  logic               adc_done,
  input  logic [DATA_W-1:0]  adc_data,
  output logic [NCH_W-1:0]   mux_ch,
  input  logic               fifo_rd,
  output logic [DATA_W-1:0]  fifo_rdata,
  output logic               fifo_empty,
  output logic [FIFO_AW:0]   fifo_count,
  output logic [DATA_W-1:0]  hold_data,
  input  logic               hold_ack,
  output logic               irq,
  output logic               overrun_flag,
  output logic               overflow_flag
);
  localparam int THR_W = FIFO_AW + 1;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_s1_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_i_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_i_n  <= rst_s1_q;
    end
  end

  seq_ctrl_t        ctrl_q;
  logic [NCH_W-1:0] first_q, len_q;
  logic [THR_W-1:0] thr_q;
  logic             we_ctrl, we_group, we_thr, soft_go, we_clr;

  assign we_ctrl  = cfg_we && (cfg_addr == ADDR_CTRL);
  assign we_group = cfg_we && (cfg_addr == ADDR_GROUP);
  assign we_thr   = cfg_we && (cfg_addr == ADDR_THR);
  assign soft_go  = cfg_we && (cfg_addr == ADDR_SOFT);
  assign we_clr   = cfg_we && (cfg_addr == ADDR_CLR);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q  <= '0;
      first_q <= '0;
      len_q   <= '0;
      thr_q   <= '0;
    end else begin
      if (we_ctrl)  ctrl_q  <= seq_ctrl_t'(cfg_wdata[3:0]);
      if (we_group) first_q <= cfg_wdata[NCH_W-1:0];
      if (we_group) len_q   <= cfg_wdata[8 +: NCH_W];
      if (we_thr)   thr_q   <= cfg_wdata[THR_W-1:0];
    end
  end

  logic              trig_sel, smp_valid, ovr_set;
  logic [DATA_W-1:0] smp_data;

  assign trig_sel = ctrl_q.scan_en && (ctrl_q.trig_ext ? ext_trig : timer_tick);

  adc_seq_ctrl #(.NCH_W(NCH_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .diff       (ctrl_q.diff),
    .trig       (trig_sel),
    .first_ch   (first_q),
    .len_m1     (len_q),
    .soft_go    (soft_go),
    .soft_ch    (cfg_wdata[NCH_W-1:0]),
    .adc_done   (adc_done),
    .adc_data   (adc_data),
    .adc_start  (adc_start),
    .mux_ch     (mux_ch),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .overrun_set(ovr_set)
  );

  logic fifo_push, fifo_full, hold_set;
  assign fifo_push = smp_valid && ctrl_q.fifo_en;
  assign hold_set  = smp_valid && !ctrl_q.fifo_en;

  adc_seq_fifo #(.DATA_W(DATA_W), .AW(FIFO_AW)) u_fifo (
    .clk  (clk),
    .rst_n(rst_i_n),
    .push (fifo_push),
    .wdata(smp_data),
    .pop  (fifo_rd),
    .rdata(fifo_rdata),
    .empty(fifo_empty),
    .full (fifo_full),
    .count(fifo_count)
  );

  // Sticky flags, write-one-to-clear, a new event wins over a clear
  logic ovr_q, ovr_d, ovf_q, ovf_d, pend_q, pend_d;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    ovr_d = ovr_q;
    ovf_d = ovf_q;
    pend_d = pend_q;
    if (we_clr && cfg_wdata[0]) ovr_d = 1'b0;
    if (we_clr && cfg_wdata[1]) ovf_d = 1'b0;
    if (ovr_set) ovr_d = 1'b1;
    if (fifo_push && fifo_full) ovf_d = 1'b1;
    if (hold_ack) pend_d = 1'b0;
    if (hold_set) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ovr_q  <= 1'b0;
      ovf_q  <= 1'b0;
      pend_q <= 1'b0;
      hold_q <= '0;
    end else begin
      ovr_q  <= ovr_d;
      ovf_q  <= ovf_d;
      pend_q <= pend_d;
      if (hold_set) hold_q <= smp_data;
    end
  end

  assign overrun_flag  = ovr_q;
  assign overflow_flag = ovf_q;
  assign hold_data     = hold_q;
  assign irq = ctrl_q.fifo_en ? ((thr_q != '0) && (fifo_count >= thr_q)) : pend_q;

  // R6: the overrun flag stays until software clears it
  a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    (overrun_flag && !(we_clr && cfg_wdata[0])) |=> overrun_flag);

  // R9: the overflow flag stays until software clears it
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_i_n)
    (overflow_flag && !(we_clr && cfg_wdata[1])) |=> overflow_flag);

  // R10: a held sample raises the request on the next cycle
  a_r10_hold_irq: assert property (@(posedge clk) disable iff (!rst_i_n)
    (hold_set && !we_ctrl) |=> irq);

endmodule

// File: tb/sim_adc_scan_seq.sv
`timescale 1ns/1ps
module sim_adc_scan_seq;
  localparam int AW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        timer_tick = 1'b0, ext_trig = 1'b0;
  logic        adc_start, adc_done = 1'b0;
  logic [15:0] adc_data = '0;
  logic [3:0]  mux_ch;
  logic        rd_task = 1'b0, rd_model = 1'b0, fifo_rd;
  logic [15:0] fifo_rdata, hold_data;
  logic        fifo_empty, irq, overrun_flag, overflow_flag;
  logic [AW:0] fifo_count;
  logic        hold_ack = 1'b0;

  assign fifo_rd = rd_task | rd_model;

  always #4 clk = ~clk;

  adc_scan_seq #(.FIFO_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .timer_tick(timer_tick), .ext_trig(ext_trig),
    .adc_start(adc_start), .adc_done(adc_done), .adc_data(adc_data),
    .mux_ch(mux_ch), .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata),
    .fifo_empty(fifo_empty), .fifo_count(fifo_count), .hold_data(hold_data),
    .hold_ack(hold_ack), .irq(irq), .overrun_flag(overrun_flag),
    .overflow_flag(overflow_flag)
  );

  int nchk = 0, nfail = 0, starts = 0, cnt = 0;
  logic rd_with_done = 1'b0;
  logic [3:0] cap = '0;
  logic [15:0] expq[$];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Converter model: three cycles of latency, result tagged with the channel
  always @(negedge clk) begin
    adc_done = 1'b0;
    rd_model = 1'b0;
    if (adc_start) starts++;
    if (cnt != 0) begin
      cnt--;
      if (cnt == 0) begin
        adc_done = 1'b1;
        adc_data = {cap, 12'hC3A};
        rd_model = rd_with_done && !fifo_empty;
      end
    end else if (adc_start) begin
      cap = mux_ch;
      cnt = 3;
    end
  end

  // Scoreboard monitor: compares each popped word with the predicted one
  always @(posedge clk) begin
    if (rst_n && fifo_rd && !fifo_empty) begin
      nchk++;
      if (expq.size() == 0) begin
        nfail++;
        $display("FAIL R7: actual %0h expected no entry", fifo_rdata);
      end else begin
        logic [15:0] e;
        e = expq.pop_front();
        if (fifo_rdata !== e) begin
          nfail++;
          $display("FAIL R4/R7: actual %0h expected %0h", fifo_rdata, e);
        end
      end
    end
  end

  // Driver side: predict the channel order of a scan (R4)
  task automatic expect_scan(input int first, input int len, input bit diff);
    int n = len;
    int m = diff ? 8 : 16;
    if (diff && n > 8) n = 8;
    for (int k = 0; k < n; k++)
      expq.push_back({4'((first % m + k) % m), 12'hC3A});
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); timer_tick = 1'b1; @(negedge clk); timer_tick = 1'b0;
  endtask

  task automatic etrig();
    @(negedge clk); ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rd_task = 1'b1;
      @(negedge clk); rd_task = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #1600000;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int s0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 count", fifo_count, 0);
    chk("R1 start", adc_start, 0);
    chk("R1 mux", mux_ch, 0);
    chk("R1 flags", {overrun_flag, overflow_flag}, 0);

    // FIFO scan with wrap, threshold interrupt
    wr(3'd0, 16'h000A);
    wr(3'd1, 16'h030E);
    wr(3'd2, 16'd4);
    idle(1);
    chk("R5 idle first", mux_ch, 14);
    expect_scan(14, 4, 0);
    s0 = starts;
    tick();
    idle(40);
    chk("R3 one start per conversion", starts - s0, 4);
    chk("R7 count", fifo_count, 4);
    chk("R8 irq at level", irq, 1);
    chk("R5 back to first", mux_ch, 14);
    drain(1);
    chk("R8 irq below level", irq, 0);
    drain(3);
    chk("R4 queue used", expq.size(), 0);
    // R7 read of empty ignored
    drain(1);
    chk("R7 empty read count", fifo_count, 0);
    chk("R7 empty read flag", fifo_empty, 1);

    // Differential mode, length clamped to 8, wrap modulo 8
    wr(3'd0, 16'h000B);
    wr(3'd1, 16'h0F06);
    wr(3'd2, 16'd0);
    expect_scan(6, 16, 1);
    tick();
    idle(70);
    chk("R4 diff count", fifo_count, 8);
    chk("R8 zero threshold", irq, 0);
    drain(8);
    chk("R4 diff queue", expq.size(), 0);

    // Trigger source selection
    wr(3'd0, 16'h000E);
    wr(3'd1, 16'h0102);
    tick();
    idle(20);
    chk("R2 timer ignored", fifo_count, 0);
    expect_scan(2, 2, 0);
    etrig();
    idle(25);
    chk("R2 ext scan", fifo_count, 2);
    drain(2);
    wr(3'd0, 16'h0006);
    etrig();
    idle(20);
    chk("R2 scan disabled", fifo_count, 0);

    // Overrun
    wr(3'd0, 16'h000A);
    wr(3'd1, 16'h0300);
    expect_scan(0, 4, 0);
    tick();
    idle(4);
    tick();
    idle(40);
    chk("R6 flag set", overrun_flag, 1);
    chk("R6 no restart", fifo_count, 4);
    drain(4);
    wr(3'd4, 16'h0001);
    chk("R6 flag cleared", overrun_flag, 0);

    // Overflow
    wr(3'd1, 16'h0F00);
    expect_scan(0, 16, 0);
    tick();
    idle(140);
    chk("R9 full", fifo_count, 16);
    wr(3'd1, 16'h0200);
    tick();
    idle(30);
    chk("R9 count kept", fifo_count, 16);
    chk("R9 flag set", overflow_flag, 1);
    drain(16);
    chk("R9 contents kept", expq.size(), 0);
    wr(3'd4, 16'h0002);
    chk("R9 flag cleared", overflow_flag, 0);

    // Same-cycle write and read
    wr(3'd1, 16'h0300);
    expect_scan(0, 4, 0);
    rd_with_done = 1'b1;
    tick();
    idle(40);
    rd_with_done = 1'b0;
    chk("R12 count held", fifo_count, 1);
    drain(1);
    chk("R12 queue", expq.size(), 0);

    // Holding register mode
    wr(3'd0, 16'h0008);
    wr(3'd1, 16'h0005);
    tick();
    idle(15);
    chk("R10 irq", irq, 1);
    chk("R10 data", hold_data, 16'h5C3A);
    @(negedge clk); hold_ack = 1'b1; @(negedge clk); hold_ack = 1'b0;
    chk("R10 ack", irq, 0);

    // Program-controlled single conversion
    wr(3'd3, 16'h0009);
    idle(15);
    chk("R11 data", hold_data, 16'h9C3A);
    chk("R11 irq", irq, 1);
    chk("R5 after single", mux_ch, 5);
    @(negedge clk); hold_ack = 1'b1; @(negedge clk); hold_ack = 1'b0;
    wr(3'd1, 16'h0301);
    tick();
    idle(2);
    wr(3'd3, 16'h000C);
    idle(50);
    chk("R11 ignored while busy", hold_data, 16'h4C3A);
    chk("R5 after scan", mux_ch, 1);

    finish_run();
  end
endmodule